// File: doc/BRIEF.md
# Circular Idle Core Claim Arbiter

This block finds a helper core that can carry out a deferred action for a requesting core, and reserves it. Each core slot keeps an action code and a data word. A slot is eligible when its in-host status input is high and its action code is zero. A request names the requester and gives a non-zero action code and a data word. The arbiter walks the slots in a circle. It starts at the slot just after the requester, wraps past the top index to slot 0, and stops just before the requester. The first eligible slot it finds is claimed: the action code and the data word are written into it. If no slot is eligible, the result reports not-found. The search and the claim happen inside one command, so no other claim can land on the same slot in between.

A claimed core gives its slot back by pulsing a release. The slot's data word is cleared first. The action code is cleared one cycle later, so a reader never sees an idle action code alongside stale data. The serial search looks at one slot per clock, so a result needs at most one cycle per slot.

Top module: `claim_arbiter`

## Requirements
- R1: After reset every slot has action code 0 and data 0, and `busy`, `done` and `found` are low.
- R2: The search visits slots in the order requester+1, requester+2, ..., NUM_SLOTS-1, 0, 1, ..., requester-1. The first eligible slot in that order is granted.
- R3: A slot is eligible only when its `slot_in_host` bit is 1 and its action code is 0. A slot that is out of host mode or busy is skipped.
- R4: A grant writes the request's action code and data word into the granted slot on the edge that raises `done`. A slot with a non-zero action code is never granted again until it has been released.
- R5: The requester's own slot is never granted, even when it is eligible.
- R6: When no slot is eligible, `done` rises with `found` low and no slot's action code or data changes.
- R7: `done` is a one-cycle pulse. It rises d clock edges after the edge that accepts the request, where d = (grant_idx - req_src) mod NUM_SLOTS for a grant and d = NUM_SLOTS-1 for not-found. `busy` is high from the accepting edge until `done` rises.
- R8: A release of a busy slot clears its data on the next edge and its action code on the edge after that. A release of a slot whose action code is already 0 changes nothing.
- R9: A request is ignored when its action code is 0 or when `busy` is high. An ignored request starts no search and produces no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_in_host | input | NUM_SLOTS | Per-slot in-host status |
| req_valid | input | 1 | Request strobe |
| req_src | input | IDX_W | Index of the requesting core |
| req_action | input | ACT_W | Action code to claim with (non-zero) |
| req_data | input | DATA_W | Data word stored in the claimed slot |
| rel_valid | input | 1 | Release strobe from a target core |
| rel_slot | input | IDX_W | Slot being released |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result pulse |
| found | output | 1 | Last result granted a slot |
| grant_idx | output | IDX_W | Slot granted by the last result |
| slot_action_flat | output | NUM_SLOTS*ACT_W | Action codes of all slots, slot i at bits [i*ACT_W +: ACT_W] |
| slot_data_flat | output | NUM_SLOTS*DATA_W | Data words of all slots, slot i at bits [i*DATA_W +: DATA_W] |

## Verification
The hardest cases to reach are those where the result depends on slot state left behind by earlier claims. Examples are a search that must skip several busy slots and wrap past the top index, and a search that finds nothing because every slot is taken. The stimulus table is therefore walked in order without any release. Each row's in-host mask and requester are chosen so that the slots claimed by earlier rows steer the next search: it wraps, skips the requester, or fails. The last row runs with every slot claimed. Directed steps then release a slot in two phases, issue a request while a search is still running, and finally claim the freed slot again.

// File: rtl/claim_arb_pkg.sv
package claim_arb_pkg;

   typedef enum logic {
      SCAN_IDLE = 1'b0,
      SCAN_RUN  = 1'b1
   } scan_state_e;

   // Circular successor of an index in a ring of n slots.
   function automatic int unsigned ring_next(input int unsigned v, input int unsigned n);
      return (v + 1 >= n) ? 0 : v + 1;
   endfunction

endpackage

// File: rtl/claim_slot_bank.sv
module claim_slot_bank #(
   parameter int NUM_SLOTS = 8,
   parameter int ACT_W     = 3,
   parameter int DATA_W    = 8,
   localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        claim_en,
   input  logic [IDX_W-1:0]            claim_idx,
   input  logic [ACT_W-1:0]            claim_action,
   input  logic [DATA_W-1:0]           claim_data,
   input  logic                        rel_valid,
   input  logic [IDX_W-1:0]            rel_slot,
   output logic [NUM_SLOTS*ACT_W-1:0]  action_flat,
   output logic [NUM_SLOTS*DATA_W-1:0] data_flat
);

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      logic [ACT_W-1:0]  act_q;
      logic [DATA_W-1:0] dat_q;
      logic              drop_pend;
      logic              hit_claim;
      logic              hit_rel;

      assign hit_claim = claim_en && (claim_idx == IDX_W'(i));
      assign hit_rel   = rel_valid && (rel_slot == IDX_W'(i)) &&
                         (act_q != '0) && !drop_pend;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            act_q     <= '0;
            dat_q     <= '0;
            drop_pend <= 1'b0;
         end else begin
            if (hit_claim) begin
               act_q <= claim_action;
               dat_q <= claim_data;
            end
            // release: data first, action code one cycle later
            if (hit_rel) begin
               dat_q     <= '0;
               drop_pend <= 1'b1;
            end
            if (drop_pend) begin
               act_q     <= '0;
               drop_pend <= 1'b0;
            end
         end
      end

      assign action_flat[i*ACT_W +: ACT_W]  = act_q;
      assign data_flat[i*DATA_W +: DATA_W]  = dat_q;
   end

endmodule

// File: rtl/claim_slot_pick.sv
module claim_slot_pick #(
   parameter int NUM_SLOTS = 8,
   parameter int ACT_W     = 3,
   localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
   input  logic [NUM_SLOTS-1:0]       slot_in_host,
   input  logic [NUM_SLOTS*ACT_W-1:0] action_flat,
   input  logic [IDX_W-1:0]           cand_idx,
   output logic                       cand_ok
);

   logic [NUM_SLOTS-1:0] idle_vec;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_idle
      assign idle_vec[i] = slot_in_host[i] &&
                           (action_flat[i*ACT_W +: ACT_W] == '0);
   end

   localparam bit POW2 = ((1 << IDX_W) == NUM_SLOTS);

   if (POW2) begin : g_direct
      assign cand_ok = idle_vec[cand_idx];
   end else begin : g_guarded
      always_comb begin
         cand_ok = 1'b0;
         for (int k = 0; k < NUM_SLOTS; k++) begin
            if (cand_idx == IDX_W'(k)) cand_ok = idle_vec[k];
         end
      end
   end

endmodule

// File: rtl/claim_scan_ctrl.sv
module claim_scan_ctrl
   import claim_arb_pkg::*;
#(
   parameter int NUM_SLOTS = 8,
   parameter int ACT_W     = 3,
   parameter int DATA_W    = 8,
   localparam int IDX_W    = $clog2(NUM_SLOTS),
   localparam int CNT_W    = (IDX_W < 1) ? 1 : IDX_W,
   localparam int LAST_STEP = NUM_SLOTS - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [IDX_W-1:0]  req_src,
   input  logic [ACT_W-1:0]  req_action,
   input  logic [DATA_W-1:0] req_data,
   input  logic              cand_ok,
   output logic [IDX_W-1:0]  cand_idx,
   output logic              claim_en,
   output logic [ACT_W-1:0]  claim_action,
   output logic [DATA_W-1:0] claim_data,
   output logic              busy,
   output logic              done,
   output logic              found,
   output logic [IDX_W-1:0]  grant_idx
);

   scan_state_e       state_q;
   logic [IDX_W-1:0]  ptr_q;
   logic [CNT_W-1:0]  step_q;
   logic [ACT_W-1:0]  act_q;
   logic [DATA_W-1:0] dat_q;
   logic              accept;
   logic              last_step;
   logic [IDX_W-1:0]  ptr_succ;
   logic [IDX_W-1:0]  src_succ;

   assign accept    = (state_q == SCAN_IDLE) && req_valid && (req_action != '0) &&
                      (int'(req_src) < NUM_SLOTS);
   assign last_step = (step_q == CNT_W'(LAST_STEP));
   assign ptr_succ  = IDX_W'(ring_next(int'(ptr_q), NUM_SLOTS));
   assign src_succ  = IDX_W'(ring_next(int'(req_src), NUM_SLOTS));

   assign cand_idx     = ptr_q;
   assign claim_en     = (state_q == SCAN_RUN) && cand_ok;
   assign claim_action = act_q;
   assign claim_data   = dat_q;
   assign busy         = (state_q == SCAN_RUN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= SCAN_IDLE;
         ptr_q     <= '0;
         step_q    <= '0;
         act_q     <= '0;
         dat_q     <= '0;
         done      <= 1'b0;
         found     <= 1'b0;
         grant_idx <= '0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            SCAN_IDLE: begin
               if (accept) begin
                  state_q <= SCAN_RUN;
                  ptr_q   <= src_succ;
                  step_q  <= '0;
                  act_q   <= req_action;
                  dat_q   <= req_data;
               end
            end
            SCAN_RUN: begin
               if (cand_ok) begin
                  state_q   <= SCAN_IDLE;
                  done      <= 1'b1;
                  found     <= 1'b1;
                  grant_idx <= ptr_q;
               end else if (last_step) begin
                  state_q <= SCAN_IDLE;
                  done    <= 1'b1;
                  found   <= 1'b0;
               end else begin
                  ptr_q  <= ptr_succ;
                  step_q <= step_q + 1'b1;
               end
            end
            default: state_q <= SCAN_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/claim_arbiter.sv
module claim_arbiter #(
   parameter int NUM_SLOTS = 8,
   parameter int ACT_W     = 3,
   parameter int DATA_W    = 8,
   localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_SLOTS-1:0]        slot_in_host,
   input  logic                        req_valid,
   input  logic [IDX_W-1:0]            req_src,
   input  logic [ACT_W-1:0]            req_action,
   input  logic [DATA_W-1:0]           req_data,
   input  logic                        rel_valid,
   input  logic [IDX_W-1:0]            rel_slot,
   output logic                        busy,
   output logic                        done,
   output logic                        found,
   output logic [IDX_W-1:0]            grant_idx,
   output logic [NUM_SLOTS*ACT_W-1:0]  slot_action_flat,
   output logic [NUM_SLOTS*DATA_W-1:0] slot_data_flat
);

   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("claim_arbiter: NUM_SLOTS must be at least 2");
   end
   if (ACT_W < 1) begin : g_bad_act
      $error("claim_arbiter: ACT_W must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("claim_arbiter: DATA_W must be at least 1");
   end

   logic              cand_ok;
   logic [IDX_W-1:0]  cand_idx;
   logic              claim_en;
   logic [ACT_W-1:0]  claim_action;
   logic [DATA_W-1:0] claim_data;

   claim_scan_ctrl #(
      .NUM_SLOTS (NUM_SLOTS),
      .ACT_W     (ACT_W),
      .DATA_W    (DATA_W)
   ) u_scan (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_src      (req_src),
      .req_action   (req_action),
      .req_data     (req_data),
      .cand_ok      (cand_ok),
      .cand_idx     (cand_idx),
      .claim_en     (claim_en),
      .claim_action (claim_action),
      .claim_data   (claim_data),
      .busy         (busy),
      .done         (done),
      .found        (found),
      .grant_idx    (grant_idx)
   );

   claim_slot_pick #(
      .NUM_SLOTS (NUM_SLOTS),
      .ACT_W     (ACT_W)
   ) u_pick (
      .slot_in_host (slot_in_host),
      .action_flat  (slot_action_flat),
      .cand_idx     (cand_idx),
      .cand_ok      (cand_ok)
   );

   claim_slot_bank #(
      .NUM_SLOTS (NUM_SLOTS),
      .ACT_W     (ACT_W),
      .DATA_W    (DATA_W)
   ) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .claim_en     (claim_en),
      .claim_idx    (cand_idx),
      .claim_action (claim_action),
      .claim_data   (claim_data),
      .rel_valid    (rel_valid),
      .rel_slot     (rel_slot),
      .action_flat  (slot_action_flat),
      .data_flat    (slot_data_flat)
   );

endmodule

// File: rtl/claim_arbiter_chk.sv
module claim_arbiter_chk #(
   parameter int NUM_SLOTS = 8,
   parameter int ACT_W     = 3,
   parameter int DATA_W    = 8,
   localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        req_valid,
   input logic [IDX_W-1:0]            req_src,
   input logic [ACT_W-1:0]            req_action,
   input logic                        busy,
   input logic                        done,
   input logic                        found,
   input logic [IDX_W-1:0]            grant_idx,
   input logic [NUM_SLOTS*ACT_W-1:0]  slot_action_flat,
   input logic [NUM_SLOTS*DATA_W-1:0] slot_data_flat
);

   logic [IDX_W-1:0] src_cap;
   logic [ACT_W-1:0] act_cap;
   int unsigned      run_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_cap <= '0;
         act_cap <= '0;
         run_len <= 0;
      end else begin
         if (req_valid && !busy && (req_action != '0)) begin
            src_cap <= req_src;
            act_cap <= req_action;
         end
         run_len <= busy ? run_len + 1 : 0;
      end
   end

   p_skip_requester_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && found) |-> (grant_idx != src_cap));

   p_claim_writes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && found) |-> (slot_action_flat[grant_idx*ACT_W +: ACT_W] == act_cap));

   p_done_ends_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_bounded_search_r7: assert property (@(posedge clk) disable iff (!rst_n)
      run_len <= NUM_SLOTS - 1);

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot_chk
      p_release_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(slot_action_flat[i*ACT_W +: ACT_W]) != '0) &&
         (slot_action_flat[i*ACT_W +: ACT_W] == '0)
         |-> ($past(slot_data_flat[i*DATA_W +: DATA_W]) == '0));

      p_only_grant_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(slot_action_flat[i*ACT_W +: ACT_W]) == '0) &&
         (slot_action_flat[i*ACT_W +: ACT_W] != '0)
         |-> (done && found && (grant_idx == IDX_W'(i))));
   end

endmodule

bind claim_arbiter claim_arbiter_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .ACT_W     (ACT_W),
   .DATA_W    (DATA_W)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .req_valid        (req_valid),
   .req_src          (req_src),
   .req_action       (req_action),
   .busy             (busy),
   .done             (done),
   .found            (found),
   .grant_idx        (grant_idx),
   .slot_action_flat (slot_action_flat),
   .slot_data_flat   (slot_data_flat)
);

// File: tb/claim_arbiter_test.sv
module claim_arbiter_test;

   localparam int N      = 8;
   localparam int ACT_W  = 3;
   localparam int DATA_W = 8;
   localparam int IDX_W  = $clog2(N);
   localparam int NVEC   = 11;

   // {host[31:24], src[23:20], act[19:16], data[15:8], found[7:4], idx[3:0]}
   localparam logic [31:0] VEC [NVEC] = '{
      32'hFF_2_1_11_1_3,
      32'hFF_2_2_22_1_4,
      32'h03_5_3_33_1_0,
      32'h03_5_4_44_1_1,
      32'h03_5_5_55_0_0,
      32'h20_5_6_66_0_0,
      32'hFF_7_7_77_1_2,
      32'h80_6_1_88_1_7,
      32'hFF_0_2_99_1_5,
      32'hFF_4_3_AA_1_6,
      32'hFF_1_4_BB_0_0
   };

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [N-1:0]            slot_in_host = '0;
   logic                    req_valid = 1'b0;
   logic [IDX_W-1:0]        req_src = '0;
   logic [ACT_W-1:0]        req_action = '0;
   logic [DATA_W-1:0]       req_data = '0;
   logic                    rel_valid = 1'b0;
   logic [IDX_W-1:0]        rel_slot = '0;
   logic                    busy;
   logic                    done;
   logic                    found;
   logic [IDX_W-1:0]        grant_idx;
   logic [N*ACT_W-1:0]      slot_action_flat;
   logic [N*DATA_W-1:0]     slot_data_flat;

   int n_checks = 0;
   int n_fails  = 0;

   always #10 clk = ~clk;

   claim_arbiter #(.NUM_SLOTS(N), .ACT_W(ACT_W), .DATA_W(DATA_W)) uut (
      .clk              (clk),
      .rst_n            (rst_n),
      .slot_in_host     (slot_in_host),
      .req_valid        (req_valid),
      .req_src          (req_src),
      .req_action       (req_action),
      .req_data         (req_data),
      .rel_valid        (rel_valid),
      .rel_slot         (rel_slot),
      .busy             (busy),
      .done             (done),
      .found            (found),
      .grant_idx        (grant_idx),
      .slot_action_flat (slot_action_flat),
      .slot_data_flat   (slot_data_flat)
   );

   function automatic int act_of(input int i);
      return int'(slot_action_flat[i*ACT_W +: ACT_W]);
   endfunction

   function automatic int dat_of(input int i);
      return int'(slot_data_flat[i*DATA_W +: DATA_W]);
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Issue one request and wait for its result; lat counts negedges after the accepting edge.
   task automatic issue(input logic [N-1:0] h, input int s, input int a, input int d,
                        output int lat, output bit got_done);
      slot_in_host = h;
      req_src      = IDX_W'(s);
      req_action   = ACT_W'(a);
      req_data     = DATA_W'(d);
      req_valid    = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      lat       = 0;
      got_done  = 1'b0;
      for (int k = 0; k < 2 * N; k++) begin
         @(negedge clk);
         lat++;
         if (done) begin
            got_done = 1'b1;
            break;
         end
      end
   endtask

   task automatic run_all();
      int lat;
      bit gd;
      logic [N*ACT_W-1:0]  act_snap;
      logic [N*DATA_W-1:0] dat_snap;

      // R1 reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(slot_action_flat == '0, "R1 actions", slot_action_flat, 0);
      check(slot_data_flat == '0, "R1 data", slot_data_flat, 0);
      check({busy, done, found} == 3'b000, "R1 flags", {busy, done, found}, 0);

      // Table walk: claims accumulate, R2 R3 R5 R6 R7 R4
      for (int v = 0; v < NVEC; v++) begin
         logic [31:0] e;
         int exp_lat;
         e = VEC[v];
         act_snap = slot_action_flat;
         dat_snap = slot_data_flat;
         issue(e[31:24], int'(e[23:20]), int'(e[19:16]), int'(e[15:8]), lat, gd);
         check(gd, "R7 done seen", gd, 1);
         check(found == e[4], "R2 found", found, e[4]);
         if (e[4]) begin
            exp_lat = (int'(e[3:0]) - int'(e[23:20]) + N) % N;
            check(grant_idx == e[2:0], "R2 grant index", grant_idx, e[3:0]);
            check(act_of(int'(e[3:0])) == int'(e[19:16]), "R4 action written",
                  act_of(int'(e[3:0])), e[19:16]);
            check(dat_of(int'(e[3:0])) == int'(e[15:8]), "R4 data written",
                  dat_of(int'(e[3:0])), e[15:8]);
         end else begin
            exp_lat = N - 1;
            check(slot_action_flat == act_snap, "R6 actions unchanged", slot_action_flat, act_snap);
            check(slot_data_flat == dat_snap, "R6 data unchanged", slot_data_flat, dat_snap);
         end
         check(lat == exp_lat, "R7 latency", lat, exp_lat);
         @(negedge clk);
         check(!done, "R7 done one cycle", done, 0);
      end

      // R8 two-phase release of slot 3
      rel_slot  = IDX_W'(3);
      rel_valid = 1'b1;
      @(negedge clk);
      rel_valid = 1'b0;
      check(dat_of(3) == 0, "R8 data cleared first", dat_of(3), 0);
      check(act_of(3) == 1, "R8 action held one cycle", act_of(3), 1);
      @(negedge clk);
      check(act_of(3) == 0, "R8 action cleared", act_of(3), 0);

      // R8 release of an idle slot changes nothing
      act_snap  = slot_action_flat;
      dat_snap  = slot_data_flat;
      rel_valid = 1'b1;
      @(negedge clk);
      rel_valid = 1'b0;
      repeat (2) @(negedge clk);
      check(slot_action_flat == act_snap, "R8 idle release actions", slot_action_flat, act_snap);
      check(slot_data_flat == dat_snap, "R8 idle release data", slot_data_flat, dat_snap);

      // R9 action code 0 is ignored
      slot_in_host = '1;
      req_src      = IDX_W'(2);
      req_action   = '0;
      req_valid    = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      gd = 1'b0;
      for (int k = 0; k < 3; k++) begin
         if (busy || done) gd = 1'b1;
         @(negedge clk);
      end
      check(!gd, "R9 zero action ignored", gd, 0);
      check(act_of(3) == 0, "R9 slot 3 untouched", act_of(3), 0);

      // R9 request while busy is ignored; R3 out-of-host idle slot skipped
      slot_in_host = 8'h01;
      req_src      = IDX_W'(2);
      req_action   = ACT_W'(5);
      req_data     = 8'hCC;
      req_valid    = 1'b1;
      @(negedge clk);
      check(busy, "R7 busy after accept", busy, 1);
      req_src = IDX_W'(6);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 2;
      while (!done && lat < 2 * N) begin
         @(negedge clk);
         lat++;
      end
      check(done && !found, "R3 idle slot out of host skipped", {done, found}, 2'b10);
      check(act_of(3) == 0, "R3 slot 3 not claimed", act_of(3), 0);
      gd = 1'b0;
      for (int k = 0; k < N + 1; k++) begin
         @(negedge clk);
         if (busy || done) gd = 1'b1;
      end
      check(!gd, "R9 busy request ignored", gd, 0);

      // R4 released slot can be granted again
      issue(8'hFF, 2, 6, 8'hDD, lat, gd);
      check(gd && found && grant_idx == IDX_W'(3), "R4 regrant after release", grant_idx, 3);
      check(lat == 1, "R7 adjacent latency", lat, 1);
      check(act_of(3) == 6 && dat_of(3) == 8'hDD, "R4 regrant contents", act_of(3), 6);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule